// File: doc/BRIEF.md
# Endpoint Calibration Pin Handshake Controller

This block runs the calibration handshake for a two-point scaled sensor front end. Two request pins exist, one for the low endpoint and one for the high endpoint. Each pin is seen by the block as an input level. Each pin also has an output enable that lets the block pull the pin high itself, as an open-drain style wired-OR with the host.

A host asks for a calibration by holding a pin high. Once the level has been stable for a qualification window, the block takes over the pin and keeps it high as a busy indication. While it holds the pin, it gathers a fixed number of burst results and forms their rounded mean with a sequential divider. It then lets go of the pin, so a low read tells the host that capture is done. The mean is written into that endpoint's register, with a one-cycle commit strobe, only after the host has released the pin as well.

Requests are ignored during a power-up hold-off interval. When both pins qualify together, the low endpoint is served first.

Top module: `cal_pin_handshake`

## Requirements
- R1: After reset both endpoint registers read 0, and both output enables, the commit strobe and the busy flag are low.
- R2: For the first HOLDOFF_CYCLES clock edges after reset, a high pin is not counted towards qualification. A pin held high through the end of hold-off still needs a full qualification window after it.
- R3: A pin is accepted on the (QUAL_CYCLES+1)-th consecutive edge at which it is sampled high after hold-off. From that edge on, its output enable and the busy flag are high. A single low sample restarts the count.
- R4: The output enable of the served pin stays high through capture and averaging. It drops exactly SUM_W+2 edges after the edge that takes the NUM_SAMPLES-th result, where SUM_W = DATA_W + ceil(log2(NUM_SAMPLES+1)).
- R5: Only the first NUM_SAMPLES results with burstValid high are used, and only while the pin is being driven. Valid results at any other time have no effect.
- R6: The stored value is the sum of the captured results plus floor(NUM_SAMPLES/2), divided by NUM_SAMPLES with the remainder dropped. This is the mean rounded to nearest, with halves rounded up.
- R7: After the drive is released, the endpoint register and commitStrobe update on the first edge that samples the served pin low. commitStrobe is high for exactly one cycle, in the same cycle the new value first appears.
- R8: calBusy is high from the accepting edge up to the commit edge. It is low in the cycle in which commitStrobe is high.
- R9: A calibration changes only its own endpoint register. The two endpoints may be calibrated in either order and any number of times.
- R10: If both pins qualify in the same cycle, the low pin (index 0) is served first. A high request whose pin is still high after the low commit is served next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| calLoIn | input | 1 | Sampled level of the low-endpoint request pin |
| calHiIn | input | 1 | Sampled level of the high-endpoint request pin |
| calLoOe | output | 1 | Block pulls the low-endpoint pin high |
| calHiOe | output | 1 | Block pulls the high-endpoint pin high |
| burstValid | input | 1 | A new burst result is present on burstData |
| burstData | input | DATA_W | Burst result value |
| loEndpoint | output | DATA_W | Stored low-endpoint value |
| hiEndpoint | output | DATA_W | Stored high-endpoint value |
| commitStrobe | output | 1 | One-cycle pulse when an endpoint register is written |
| calBusy | output | 1 | A calibration is in progress |

## Verification
Two collisions are provoked on purpose. In the first, both pins rise on the same cycle, so both qualification counters saturate on the same edge and the selector must pick the low pin. In the second, the high request keeps qualifying while the low calibration runs, so the low commit and the start of the high service fall on back-to-back edges. A behavioural model of the whole handshake, built from counters and a phase number, predicts every output on every cycle. Directed checks also confirm which enable rose first and that each endpoint holds its value while the other is written. Valid results arriving just as capture completes, and host releases made both before and after the drive drops, are judged the same way.

// File: rtl/calpin_pkg.sv
package calpin_pkg;

  localparam int unsigned NUM_PINS = 2;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CAPT = 2'd1,
    ST_AVG  = 2'd2,
    ST_HAND = 2'd3
  } calState_t;

  // control -> datapath strobes
  typedef struct packed {
    logic clrAcc;
    logic capEn;
    logic startDiv;
    logic commitLo;
    logic commitHi;
  } calStrobe_t;

endpackage

// File: rtl/cal_pin_qual.sv
module cal_pin_qual #(
  parameter int unsigned QUAL_CYCLES = 250000
) (
  input  logic clk,
  input  logic rstN,
  input  logic armed,
  input  logic pinIn,
  output logic qualified
);
  localparam int unsigned QW = $clog2(QUAL_CYCLES + 1);
  localparam logic [QW-1:0] QMAX = QW'(QUAL_CYCLES);

  logic [QW-1:0] highCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 highCnt <= '0;
    else if (!armed || !pinIn) highCnt <= '0;
    else if (highCnt != QMAX)  highCnt <= highCnt + 1'b1;
  end

  assign qualified = (highCnt == QMAX);
endmodule

// File: rtl/cal_ctrl.sv
module cal_ctrl
  import calpin_pkg::*;
#(
  parameter int unsigned HOLDOFF_CYCLES = 30000000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       qualLo,
  input  logic       qualHi,
  input  logic       pinLo,
  input  logic       pinHi,
  input  logic       capDone,
  input  logic       divDone,
  output logic       armed,
  output calStrobe_t strb,
  output logic       oeLo,
  output logic       oeHi,
  output logic       busy
);
  localparam int unsigned HW = $clog2(HOLDOFF_CYCLES + 1);
  localparam logic [HW-1:0] HMAX = HW'(HOLDOFF_CYCLES);

  logic [HW-1:0] holdCnt;
  calState_t     state, nextState;
  logic          selHi, nextSel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                holdCnt <= '0;
    else if (holdCnt != HMAX) holdCnt <= holdCnt + 1'b1;
  end
  assign armed = (holdCnt == HMAX);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      selHi <= 1'b0;
    end else begin
      state <= nextState;
      selHi <= nextSel;
    end
  end

  always_comb begin
    nextState = state;
    nextSel   = selHi;
    strb      = '0;
    unique case (state)
      ST_IDLE: begin
        if (qualLo) begin
          nextState   = ST_CAPT;
          nextSel     = 1'b0;
          strb.clrAcc = 1'b1;
        end else if (qualHi) begin
          nextState   = ST_CAPT;
          nextSel     = 1'b1;
          strb.clrAcc = 1'b1;
        end
      end
      ST_CAPT: begin
        strb.capEn = 1'b1;
        if (capDone) begin
          strb.startDiv = 1'b1;
          nextState     = ST_AVG;
        end
      end
      ST_AVG: begin
        if (divDone) nextState = ST_HAND;
      end
      ST_HAND: begin
        if (selHi ? !pinHi : !pinLo) begin
          strb.commitLo = !selHi;
          strb.commitHi = selHi;
          nextState     = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assign oeLo = (state == ST_CAPT || state == ST_AVG) && !selHi;
  assign oeHi = (state == ST_CAPT || state == ST_AVG) &&  selHi;
  assign busy = (state != ST_IDLE);
endmodule

// File: rtl/cal_data.sv
module cal_data
  import calpin_pkg::*;
#(
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned NUM_SAMPLES = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  calStrobe_t        strb,
  input  logic              burstValid,
  input  logic [DATA_W-1:0] burstData,
  output logic              capDone,
  output logic              divDone,
  output logic [DATA_W-1:0] loEndpoint,
  output logic [DATA_W-1:0] hiEndpoint,
  output logic              commitStrobe
);
  localparam int unsigned CW    = $clog2(NUM_SAMPLES + 1);
  localparam int unsigned SUM_W = DATA_W + CW;
  localparam int unsigned RW    = $clog2(NUM_SAMPLES) + 2;
  localparam int unsigned DCW   = $clog2(SUM_W + 1);
  localparam int unsigned HALF  = NUM_SAMPLES / 2;

  logic [SUM_W-1:0]  sum, quo;
  logic [CW-1:0]     smpCnt;
  logic [RW-1:0]     rem, remShift;
  logic [DCW-1:0]    divCnt;
  logic              divBusy, fits;
  logic [DATA_W-1:0] avgSat;

  assign capDone = (smpCnt == CW'(NUM_SAMPLES));
  assign divDone = divBusy && (divCnt == '0);

  // accumulator
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sum    <= '0;
      smpCnt <= '0;
    end else if (strb.clrAcc) begin
      sum    <= '0;
      smpCnt <= '0;
    end else if (strb.capEn && burstValid && !capDone) begin
      sum    <= sum + SUM_W'(burstData);
      smpCnt <= smpCnt + 1'b1;
    end
  end

  // restoring divider, one quotient bit per cycle
  assign remShift = {rem[RW-2:0], quo[SUM_W-1]};
  assign fits     = (remShift >= RW'(NUM_SAMPLES));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      quo     <= '0;
      rem     <= '0;
      divCnt  <= '0;
      divBusy <= 1'b0;
    end else if (strb.startDiv) begin
      quo     <= sum + SUM_W'(HALF);
      rem     <= '0;
      divCnt  <= DCW'(SUM_W);
      divBusy <= 1'b1;
    end else if (divBusy) begin
      if (divCnt == '0) begin
        divBusy <= 1'b0;
      end else begin
        rem    <= fits ? remShift - RW'(NUM_SAMPLES) : remShift;
        quo    <= {quo[SUM_W-2:0], fits};
        divCnt <= divCnt - 1'b1;
      end
    end
  end

  assign avgSat = (|quo[SUM_W-1:DATA_W]) ? '1 : quo[DATA_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loEndpoint   <= '0;
      hiEndpoint   <= '0;
      commitStrobe <= 1'b0;
    end else begin
      commitStrobe <= strb.commitLo | strb.commitHi;
      if (strb.commitLo) loEndpoint <= avgSat;
      if (strb.commitHi) hiEndpoint <= avgSat;
    end
  end
endmodule

// File: rtl/cal_pin_handshake.sv
module cal_pin_handshake
  import calpin_pkg::*;
#(
  parameter int unsigned DATA_W         = 16,
  parameter int unsigned NUM_SAMPLES    = 15,
  parameter int unsigned QUAL_CYCLES    = 250000,
  parameter int unsigned HOLDOFF_CYCLES = 30000000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              calLoIn,
  input  logic              calHiIn,
  output logic              calLoOe,
  output logic              calHiOe,
  input  logic              burstValid,
  input  logic [DATA_W-1:0] burstData,
  output logic [DATA_W-1:0] loEndpoint,
  output logic [DATA_W-1:0] hiEndpoint,
  output logic              commitStrobe,
  output logic              calBusy
);
  logic [NUM_PINS-1:0] pinLvl, qualVec;
  logic                armed, capDone, divDone;
  calStrobe_t          strb;

  assign pinLvl = {calHiIn, calLoIn};

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_qual
    cal_pin_qual #(.QUAL_CYCLES(QUAL_CYCLES)) u_qual (
      .clk      (clk),
      .rstN     (rstN),
      .armed    (armed),
      .pinIn    (pinLvl[p]),
      .qualified(qualVec[p])
    );
  end

  cal_ctrl #(.HOLDOFF_CYCLES(HOLDOFF_CYCLES)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .qualLo (qualVec[0]),
    .qualHi (qualVec[1]),
    .pinLo  (calLoIn),
    .pinHi  (calHiIn),
    .capDone(capDone),
    .divDone(divDone),
    .armed  (armed),
    .strb   (strb),
    .oeLo   (calLoOe),
    .oeHi   (calHiOe),
    .busy   (calBusy)
  );

  cal_data #(.DATA_W(DATA_W), .NUM_SAMPLES(NUM_SAMPLES)) u_data (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .burstValid  (burstValid),
    .burstData   (burstData),
    .capDone     (capDone),
    .divDone     (divDone),
    .loEndpoint  (loEndpoint),
    .hiEndpoint  (hiEndpoint),
    .commitStrobe(commitStrobe)
  );
endmodule

// File: rtl/cal_pin_handshake_chk.sv
module cal_pin_handshake_chk #(
  parameter int unsigned DATA_W         = 16,
  parameter int unsigned HOLDOFF_CYCLES = 30000000
) (
  input logic              clk,
  input logic              rstN,
  input logic              calLoOe,
  input logic              calHiOe,
  input logic [DATA_W-1:0] loEndpoint,
  input logic [DATA_W-1:0] hiEndpoint,
  input logic              commitStrobe,
  input logic              calBusy
);
  localparam int unsigned HW = $clog2(HOLDOFF_CYCLES + 1);
  logic [HW-1:0] upCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          upCnt <= '0;
    else if (upCnt != HW'(HOLDOFF_CYCLES)) upCnt <= upCnt + 1'b1;
  end

  // R2
  holdoff_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (upCnt != HW'(HOLDOFF_CYCLES)) |-> (!calBusy && !calLoOe && !calHiOe));

  // R10
  single_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({calLoOe, calHiOe}));

  // R4
  drive_means_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (calLoOe || calHiOe) |-> calBusy);

  // R7
  commit_after_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    commitStrobe |-> $past(!calLoOe && !calHiOe));

  // R7
  commit_single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    commitStrobe |=> !commitStrobe);

  // R8
  busy_ends_at_commit_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(calBusy) |-> commitStrobe);

  // R8
  commit_not_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    commitStrobe |-> !calBusy);

  // R9
  lo_only_on_commit_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(loEndpoint) |-> commitStrobe);

  // R9
  hi_only_on_commit_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(hiEndpoint) |-> commitStrobe);

  // R9
  one_endpoint_per_commit_chk: assert property (@(posedge clk) disable iff (!rstN)
    !($stable(loEndpoint) == 1'b0 && $stable(hiEndpoint) == 1'b0));
endmodule

bind cal_pin_handshake cal_pin_handshake_chk #(
  .DATA_W(DATA_W),
  .HOLDOFF_CYCLES(HOLDOFF_CYCLES)
) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .calLoOe     (calLoOe),
  .calHiOe     (calHiOe),
  .loEndpoint  (loEndpoint),
  .hiEndpoint  (hiEndpoint),
  .commitStrobe(commitStrobe),
  .calBusy     (calBusy)
);

// File: tb/test_cal_pin_handshake.sv
`timescale 1ns/1ps
module test_cal_pin_handshake;
  localparam int PU   = 50;
  localparam int QL   = 20;
  localparam int NS   = 15;
  localparam int DW   = 8;
  localparam int SUMW = DW + $clog2(NS + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostLo = 1'b0, hostHi = 1'b0;
  logic bValid = 1'b0;
  logic [DW-1:0] bData = '0;
  logic calLoOe, calHiOe, commitStrobe, calBusy;
  logic [DW-1:0] loEndpoint, hiEndpoint;
  logic calLoIn, calHiIn;

  assign calLoIn = hostLo | calLoOe;
  assign calHiIn = hostHi | calHiOe;

  always #5 clk = ~clk;

  cal_pin_handshake #(
    .DATA_W(DW), .NUM_SAMPLES(NS), .QUAL_CYCLES(QL), .HOLDOFF_CYCLES(PU)
  ) i_cal_pin_handshake (
    .clk(clk), .rstN(rstN), .calLoIn(calLoIn), .calHiIn(calHiIn),
    .calLoOe(calLoOe), .calHiOe(calHiOe), .burstValid(bValid), .burstData(bData),
    .loEndpoint(loEndpoint), .hiEndpoint(hiEndpoint),
    .commitStrobe(commitStrobe), .calBusy(calBusy)
  );

  int checks = 0, fails = 0, cyc = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int mHold, mQLo, mQHi, mPhase, mSel, mN, mSum, mWait, mAvg, mLo, mHi;
  bit mCommit, mReady, mQualLo, mQualHi, mOeL, mOeH, mPL, mPH;

  always @(posedge clk) begin
    if (!rstN) begin
      mHold = 0; mQLo = 0; mQHi = 0; mPhase = 0; mSel = 0; mN = 0; mSum = 0;
      mWait = 0; mAvg = 0; mLo = 0; mHi = 0; mCommit = 0;
    end else begin
      mReady  = (mHold == PU);
      mQualLo = (mQLo == QL);
      mQualHi = (mQHi == QL);
      mOeL = (mPhase == 1 || mPhase == 2) && mSel == 0;
      mOeH = (mPhase == 1 || mPhase == 2) && mSel == 1;
      mPL = hostLo || mOeL;
      mPH = hostHi || mOeH;
      mCommit = 0;
      case (mPhase)
        0: if (mQualLo) begin mPhase = 1; mSel = 0; mN = 0; mSum = 0; end
           else if (mQualHi) begin mPhase = 1; mSel = 1; mN = 0; mSum = 0; end
        1: if (mN == NS) begin mPhase = 2; mWait = SUMW; end
           else if (bValid) begin mSum += int'(bData); mN++; end
        2: if (mWait == 0) begin mPhase = 3; mAvg = (mSum + NS / 2) / NS; end
           else mWait--;
        default: if ((mSel == 0 && !mPL) || (mSel == 1 && !mPH)) begin
                   if (mSel == 0) mLo = mAvg; else mHi = mAvg;
                   mCommit = 1; mPhase = 0;
                 end
      endcase
      mQLo = (!mReady || !mPL) ? 0 : ((mQLo < QL) ? mQLo + 1 : mQLo);
      mQHi = (!mReady || !mPH) ? 0 : ((mQHi < QL) ? mQHi + 1 : mQHi);
      if (mHold < PU) mHold++;
    end
  end

  // per-cycle comparison, sampled 3 ns after the edge
  always @(posedge clk) begin
    #3;
    if (rstN) begin
      chk("R9 model loEndpoint", int'(loEndpoint), mLo);
      chk("R9 model hiEndpoint", int'(hiEndpoint), mHi);
      chk("R7 model commitStrobe", int'(commitStrobe), int'(mCommit));
      chk("R8 model calBusy", int'(calBusy), int'(mPhase != 0));
      chk("R4 model calLoOe", int'(calLoOe), int'((mPhase == 1 || mPhase == 2) && mSel == 0));
      chk("R4 model calHiOe", int'(calHiOe), int'((mPhase == 1 || mPhase == 2) && mSel == 1));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      fails++; checks++;
      $display("FAIL watchdog: actual %0d expected finish", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic sample(input int v);
    @(negedge clk); bValid = 1'b1; bData = DW'(v);
  endtask
  task automatic idle();
    @(negedge clk); bValid = 1'b0;
  endtask
  task automatic waitCommit();
    while (!commitStrobe) @(negedge clk);
  endtask

  initial begin
    int cnt;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 loEndpoint", int'(loEndpoint), 0);
    chk("R1 hiEndpoint", int'(hiEndpoint), 0);
    chk("R1 busy/oe/commit", int'({calBusy, calLoOe, calHiOe, commitStrobe}), 0);

    // R2: request raised during hold-off, dropped before a full window afterwards
    hostLo = 1'b1;
    repeat (PU + QL - 5) begin sample(9); end
    idle();
    hostLo = 1'b0;
    repeat (4) @(negedge clk);
    chk("R2 no calibration from hold-off request", int'(calBusy), 0);
    chk("R5 idle results ignored lo", int'(loEndpoint), 0);

    // R3: window one short
    hostHi = 1'b1;
    repeat (QL - 1) @(negedge clk);
    hostHi = 1'b0;
    repeat (4) @(negedge clk);
    chk("R3 short pulse rejected", int'(calBusy), 0);

    // R3 timing, R4 drive window, R6 rounding up
    hostLo = 1'b1;
    cnt = 0;
    while (!calLoOe) begin @(negedge clk); cnt++; end
    chk("R3 accept edge count", cnt, QL + 1);
    chk("R8 busy at accept", int'(calBusy), 1);
    hostLo = 1'b0;
    repeat (NS - 1) sample(0);
    sample(8);
    idle();
    cnt = 0;
    while (calLoOe) begin @(negedge clk); cnt++; end
    chk("R4 drive release delay", cnt, SUMW + 2);
    waitCommit();
    chk("R6 round 8/15 up", int'(loEndpoint), 1);
    chk("R7 commit pulse", int'(commitStrobe), 1);

    // R5 extra results, R7 host holds pin after release
    @(negedge clk);
    hostHi = 1'b1;
    while (!calHiOe) @(negedge clk);
    for (int i = 0; i < 20; i++) sample(40 + i * 11);
    idle();
    while (calHiOe) @(negedge clk);
    repeat (10) begin
      @(negedge clk);
      chk("R7 no commit while host holds", int'(commitStrobe), 0);
      chk("R8 busy while host holds", int'(calBusy), 1);
    end
    hostHi = 1'b0;
    @(negedge clk);
    chk("R7 commit on host release", int'(commitStrobe), 1);
    chk("R5 first results only", int'(hiEndpoint), 117);
    chk("R8 busy low at commit", int'(calBusy), 0);
    chk("R9 lo kept", int'(loEndpoint), 1);

    // R6 full scale, R9 recalibrate one endpoint
    @(negedge clk);
    hostLo = 1'b1;
    while (!calLoOe) @(negedge clk);
    hostLo = 1'b0;
    repeat (NS) sample(255);
    idle();
    waitCommit();
    chk("R6 full scale", int'(loEndpoint), 255);
    chk("R9 hi kept", int'(hiEndpoint), 117);

    // R10 both at once
    @(negedge clk);
    hostLo = 1'b1; hostHi = 1'b1;
    while (!calBusy) @(negedge clk);
    chk("R10 low served first", int'(calLoOe), 1);
    chk("R10 high waits", int'(calHiOe), 0);
    hostLo = 1'b0;
    repeat (NS) sample(20);
    idle();
    waitCommit();
    chk("R10 low value", int'(loEndpoint), 20);
    while (!calHiOe) @(negedge clk);
    repeat (NS - 1) sample(0);
    sample(7);
    idle();
    hostHi = 1'b0;
    waitCommit();
    chk("R6 round 7/15 down", int'(hiEndpoint), 0);
    chk("R9 lo kept after high", int'(loEndpoint), 20);

    repeat (5) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule